// File: doc/BRIEF.md
# Forth Stack Processor Core

This block is a 16-bit processor built around two hardware stacks. It executes one instruction per clock and its instruction set fits the primitive words of a Forth system. The top of the data stack lives in its own register, called T here. The next value below it is N, and the top of the return stack is R. Each instruction is fetched from an attached program memory. The core gives the fetch address and receives the instruction word back in the same cycle.

Data accesses go through a single port. That port carries an address, the write data (always T), a write strobe and a read data input, and it serves both program RAM and memory-mapped IO. A hold input freezes the core. An interrupt request input carries a vector number. Once interrupts are enabled, a pending request turns into a call to the address equal to that number.

The instruction word has five forms: literal, branch, conditional branch, call, and ALU. The ALU form carries separate signed deltas for the data stack and the return stack, plus four transfer flags. Most Forth primitives therefore need a single instruction; a store needs two.

Top module: `stack_cpu`

## Requirements
- R1: An instruction with bit 15 set is a literal: bits 14:0, zero-extended, become T, and the old T is pushed below it.
- R2: When bit 15 is clear, bits 14:13 select the form. 00 is a branch to bits 12:0. 01 is a conditional branch: it pops T, and it branches to bits 12:0 only when the popped value was zero; otherwise it goes to PC+1.
- R3: Form 10 is a call: PC+1 is pushed onto the return stack and PC is set to bits 12:0. In the ALU form, flag bit 4 (return flag) loads PC from R.
- R4: Form 11 is the ALU form, with the operation code in bits 12:8. The result replaces T. Codes: 0 T, 1 N, 2 T+N, 3 T&N, 4 T|N, 5 T^N, 6 ~T, 7 T==N, 8 signed N<T, 9 N logically shifted right by T[3:0], 10 T-1, 11 R, 12 memory read at address T, 13 N shifted left by T[3:0], 14 data depth, 15 unsigned N<T, 16 N (and interrupt enable takes T[0]), 17 interrupt enable in bit 0, 18 return depth, 19 T==0, 20 CPU_ID. Codes 21 to 31 leave T unchanged.
- R5: In the ALU form, bits 1:0 are a signed data stack delta and bits 3:2 a signed return stack delta (01 = +1, 11 = -1, 10 = -2, 00 = 0). Bit 7 writes the old T into the new N slot. Bit 6 writes T into the new R slot.
- R6: The results of codes 7, 8, 15 and 19 are 16'hFFFF for true and 16'h0000 for false.
- R7: ALU bit 5 (store flag) writes T to the address held in N: mem_we is high for that one cycle, mem_addr shows N and mem_wdata shows T.
- R8: For addresses below IO_BASE (16'h4000), the core drives address bit 0 as 0 on mem_addr, for loads and stores alike. At or above IO_BASE the full address is driven.
- R9: While hold is high, PC, T, both stacks and the interrupt enable keep their values, and mem_we stays low.
- R10: When interrupts are enabled and a request is pending, the core skips the fetched instruction. In its place it calls the vector address: the address of the skipped instruction goes onto the return stack, PC is set to the vector number, and interrupt enable is cleared.
- R11: Requests are latched per vector number while interrupts are disabled and are not acted on until they are enabled. When several are pending, the lowest number is served first.
- R12: Reset sets PC, T, both stack pointers and interrupt enable to zero.
- R13: The data stack holds 65 values (T plus 64 cells), and all of them come back in reverse order of pushing.
- R14: Right after reset, code 14 returns the number of data cells pushed since reset, code 18 returns 0 and code 17 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Freezes the core while high |
| irq_req | input | 1 | Interrupt request strobe |
| irq_num | input | VEC_W | Vector number of the request |
| pc_out | output | 13 | Fetch address into program memory |
| insn_in | input | 16 | Instruction word at pc_out |
| mem_addr | output | 16 | Data/IO address |
| mem_wdata | output | 16 | Write data (current T) |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data for address mem_addr |

## Verification
T is always visible on mem_wdata, so a wrong ALU result or a corrupted stack cell shows up at the port in the cycle after the instruction that produced it. Errors in the stack pointers stay hidden until a later pop or depth read brings the wrong cell into T, which can be many instructions later. For that reason the bench pops the full 65-deep stack and reads the depth counters directly. A wrong PC shows at pc_out at once. A wrong interrupt enable or pending state only shows as a vector call that is missing, early, or in the wrong order.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;

   localparam int WORD_W = 16;
   localparam int PC_W   = 13;

   typedef enum logic [4:0] {
      OP_T      = 5'd0,
      OP_N      = 5'd1,
      OP_ADD    = 5'd2,
      OP_AND    = 5'd3,
      OP_OR     = 5'd4,
      OP_XOR    = 5'd5,
      OP_INV    = 5'd6,
      OP_EQ     = 5'd7,
      OP_LTS    = 5'd8,
      OP_SHR    = 5'd9,
      OP_DEC    = 5'd10,
      OP_R      = 5'd11,
      OP_LOAD   = 5'd12,
      OP_SHL    = 5'd13,
      OP_DEPTH  = 5'd14,
      OP_LTU    = 5'd15,
      OP_SETIE  = 5'd16,
      OP_GETIE  = 5'd17,
      OP_RDEPTH = 5'd18,
      OP_ZEQ    = 5'd19,
      OP_ID     = 5'd20
   } alu_op_e;

   typedef enum logic [1:0] {
      FORM_JMP  = 2'b00,
      FORM_CJMP = 2'b01,
      FORM_CALL = 2'b10,
      FORM_ALU  = 2'b11
   } form_e;

endpackage

// File: rtl/stack_lifo.sv
module stack_lifo #(
   parameter int W     = 16,
   parameter int CELLS = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic [1:0]                 delta,
   input  logic                       wr,
   input  logic [W-1:0]               wdata,
   output logic [W-1:0]               top,
   output logic [$clog2(CELLS)-1:0]   ptr
);
   localparam int PW = $clog2(CELLS);

   generate
      if (CELLS < 4 || (CELLS & (CELLS - 1)) != 0) begin : g_bad_cells
         $error("stack_lifo: CELLS must be a power of two, at least 4");
      end
   endgenerate

   logic [W-1:0]  cells [CELLS];
   logic [PW-1:0] ptr_q, ptr_n;

   assign ptr_n = ptr_q + {{(PW-2){delta[1]}}, delta};
   assign ptr   = ptr_q;
   assign top   = cells[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr_q <= '0;
      else if (en) ptr_q <= ptr_n;
   end

   always_ff @(posedge clk) begin
      if (en && wr) cells[ptr_n] <= wdata;
   end

   // R5: pointer moves only when enabled
   a_r5_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(ptr_q));
   // R5: a written cell becomes the new top
   a_r5_write_top: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr) |=> top == $past(wdata));

endmodule

// File: rtl/stack_alu.sv
module stack_alu
   import stack_cpu_pkg::*;
#(
   parameter int          W      = 16,
   parameter int          DPW    = 6,
   parameter int          RPW    = 6,
   parameter logic [15:0] CPU_ID = 16'h0F02
) (
   input  logic [4:0]     op,
   input  logic [W-1:0]   t,
   input  logic [W-1:0]   n,
   input  logic [W-1:0]   r,
   input  logic [W-1:0]   rdata,
   input  logic [DPW-1:0] dpth,
   input  logic [RPW-1:0] rdpth,
   input  logic           ie,
   output logic [W-1:0]   res
);
   localparam int SHW = $clog2(W);

   always_comb begin
      unique case (op)
         OP_T:      res = t;
         OP_N:      res = n;
         OP_ADD:    res = t + n;
         OP_AND:    res = t & n;
         OP_OR:     res = t | n;
         OP_XOR:    res = t ^ n;
         OP_INV:    res = ~t;
         OP_EQ:     res = {W{t == n}};
         OP_LTS:    res = {W{$signed(n) < $signed(t)}};
         OP_SHR:    res = n >> t[SHW-1:0];
         OP_DEC:    res = t - 1'b1;
         OP_R:      res = r;
         OP_LOAD:   res = rdata;
         OP_SHL:    res = n << t[SHW-1:0];
         OP_DEPTH:  res = {{(W-DPW){1'b0}}, dpth};
         OP_LTU:    res = {W{n < t}};
         OP_SETIE:  res = n;
         OP_GETIE:  res = {{(W-1){1'b0}}, ie};
         OP_RDEPTH: res = {{(W-RPW){1'b0}}, rdpth};
         OP_ZEQ:    res = {W{t == '0}};
         OP_ID:     res = CPU_ID;
         default:   res = t;
      endcase
   end

endmodule

// File: rtl/stack_cpu.sv
module stack_cpu
   import stack_cpu_pkg::*;
#(
   parameter int          DS_CELLS = 64,
   parameter int          RS_CELLS = 64,
   parameter int          VEC_W    = 3,
   parameter logic [15:0] IO_BASE  = 16'h4000,
   parameter logic [15:0] CPU_ID   = 16'h0F02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_num,
   output logic [12:0]      pc_out,
   input  logic [15:0]      insn_in,
   output logic [15:0]      mem_addr,
   output logic [15:0]      mem_wdata,
   output logic             mem_we,
   input  logic [15:0]      mem_rdata
);
   localparam int W   = WORD_W;
   localparam int DPW = $clog2(DS_CELLS);
   localparam int RPW = $clog2(RS_CELLS);
   localparam int NV  = 1 << VEC_W;

   generate
      if (VEC_W < 1 || VEC_W > PC_W) begin : g_bad_vec
         $error("stack_cpu: VEC_W out of range");
      end
   endgenerate

   logic [PC_W-1:0] pc_q, pc_n;
   logic [W-1:0]    t_q, t_n;
   logic            ie_q, ie_n;
   logic [NV-1:0]   pend_q;
   logic [VEC_W-1:0] vec;
   logic            take, exec;

   logic            is_lit, is_jmp, is_cjmp, is_call, is_alu;
   logic [PC_W-1:0] target, pc_inc, vec_pc;
   logic [W-1:0]    n_val, r_val, alu_res, raw_addr;
   logic [DPW-1:0]  dptr;
   logic [RPW-1:0]  rptr;

   logic            ds_en, ds_wr, rs_en, rs_wr;
   logic [1:0]      ds_delta, rs_delta;
   logic [W-1:0]    rs_wdata;

   // decode
   assign is_lit  = insn_in[15];
   assign is_jmp  = !is_lit && form_e'(insn_in[14:13]) == FORM_JMP;
   assign is_cjmp = !is_lit && form_e'(insn_in[14:13]) == FORM_CJMP;
   assign is_call = !is_lit && form_e'(insn_in[14:13]) == FORM_CALL;
   assign is_alu  = !is_lit && form_e'(insn_in[14:13]) == FORM_ALU;
   assign target  = insn_in[PC_W-1:0];
   assign pc_inc  = pc_q + 1'b1;

   // interrupt selection: lowest pending number wins
   always_comb begin
      vec = '0;
      for (int i = NV - 1; i >= 0; i--)
         if (pend_q[i]) vec = VEC_W'(i);
   end
   assign vec_pc = {{(PC_W-VEC_W){1'b0}}, vec};
   assign take   = ie_q && (|pend_q) && !hold;
   assign exec   = !hold && !take;

   // stacks
   assign ds_en    = exec && (is_lit || is_cjmp || is_alu);
   assign ds_delta = is_lit ? 2'b01 : (is_cjmp ? 2'b11 : insn_in[1:0]);
   assign ds_wr    = is_lit || (is_alu && insn_in[7]);

   assign rs_en    = take || (exec && (is_call || is_alu));
   assign rs_delta = (take || is_call) ? 2'b01 : insn_in[3:2];
   assign rs_wr    = take || is_call || (is_alu && insn_in[6]);
   assign rs_wdata = take    ? {{(W-PC_W){1'b0}}, pc_q} :
                     is_call ? {{(W-PC_W){1'b0}}, pc_inc} : t_q;

   stack_lifo #(.W(W), .CELLS(DS_CELLS)) u_dstk (
      .clk(clk), .rst_n(rst_n), .en(ds_en), .delta(ds_delta),
      .wr(ds_wr), .wdata(t_q), .top(n_val), .ptr(dptr));

   stack_lifo #(.W(W), .CELLS(RS_CELLS)) u_rstk (
      .clk(clk), .rst_n(rst_n), .en(rs_en), .delta(rs_delta),
      .wr(rs_wr), .wdata(rs_wdata), .top(r_val), .ptr(rptr));

   stack_alu #(.W(W), .DPW(DPW), .RPW(RPW), .CPU_ID(CPU_ID)) u_alu (
      .op(insn_in[12:8]), .t(t_q), .n(n_val), .r(r_val), .rdata(mem_rdata),
      .dpth(dptr), .rdpth(rptr), .ie(ie_q), .res(alu_res));

   // next state
   always_comb begin
      pc_n = pc_q;
      t_n  = t_q;
      ie_n = ie_q;
      if (take) begin
         pc_n = vec_pc;
         ie_n = 1'b0;
      end else if (exec) begin
         if (is_lit) begin
            t_n  = {1'b0, insn_in[14:0]};
            pc_n = pc_inc;
         end else if (is_jmp) begin
            pc_n = target;
         end else if (is_cjmp) begin
            t_n  = n_val;
            pc_n = (t_q == '0) ? target : pc_inc;
         end else if (is_call) begin
            pc_n = target;
         end else begin
            t_n  = alu_res;
            pc_n = insn_in[4] ? r_val[PC_W-1:0] : pc_inc;
            if (alu_op_e'(insn_in[12:8]) == OP_SETIE) ie_n = t_q[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         t_q    <= '0;
         ie_q   <= 1'b0;
         pend_q <= '0;
      end else begin
         pc_q   <= pc_n;
         t_q    <= t_n;
         ie_q   <= ie_n;
         pend_q <= (pend_q & ~(take ? (NV'(1) << vec) : '0))
                 | (irq_req ? (NV'(1) << irq_num) : '0);
      end
   end

   // data port
   assign raw_addr = (is_alu && insn_in[5]) ? n_val : t_q;
   generate
      if (IO_BASE == 16'h0000) begin : g_flat_addr
         assign mem_addr = raw_addr;
      end else begin : g_split_addr
         assign mem_addr = (raw_addr < IO_BASE) ? {raw_addr[W-1:1], 1'b0} : raw_addr;
      end
   endgenerate
   assign mem_wdata = t_q;
   assign mem_we    = exec && is_alu && insn_in[5];
   assign pc_out    = pc_q;

   // R9: hold freezes the core
   a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(pc_q) && $stable(t_q) && $stable(ie_q));
   a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !mem_we);
   // R1: literal lands in T
   a_r1_literal: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && is_lit) |=> t_q == {1'b0, $past(insn_in[14:0])});
   // R3: call jumps and leaves the return address on R
   a_r3_call: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && is_call) |=> pc_q == $past(insn_in[12:0])
                            && r_val == {3'b000, $past(pc_q) + 13'd1});
   // R2: non-zero T falls through a conditional branch
   a_r2_cjmp_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && is_cjmp && t_q != '0) |=> pc_q == $past(pc_q) + 13'd1);
   // R10: interrupt entry calls the vector and disables interrupts
   a_r10_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> pc_q == $past(vec_pc) && !ie_q
               && r_val == {3'b000, $past(pc_q)});

endmodule

// File: tb/stack_cpu_tb_top.sv
module stack_cpu_tb_top;
   localparam logic [15:0] TB_ID = 16'h0F02;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0;
   logic        irq_req = 1'b0;
   logic [2:0]  irq_num = '0;
   logic [12:0] pc_out;
   logic [15:0] insn_in, mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;

   logic [15:0] prog [256];
   logic [15:0] dmem [256];
   int ntot = 0;
   int nbad = 0;

   always #10 clk = ~clk;

   assign insn_in   = prog[pc_out[7:0]];
   assign mem_rdata = dmem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) dmem[mem_addr[7:0]] <= mem_wdata;

   stack_cpu dut_i (
      .clk(clk), .rst_n(rst_n), .hold(hold), .irq_req(irq_req), .irq_num(irq_num),
      .pc_out(pc_out), .insn_in(insn_in), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

   function automatic logic [15:0] lit(input logic [14:0] v);
      return {1'b1, v};
   endfunction
   function automatic logic [15:0] jmp(input logic [12:0] a);
      return {3'b000, a};
   endfunction
   function automatic logic [15:0] cjmp(input logic [12:0] a);
      return {3'b001, a};
   endfunction
   function automatic logic [15:0] call(input logic [12:0] a);
      return {3'b010, a};
   endfunction
   function automatic logic [15:0] alu(input logic [4:0] op, input logic t2n, t2r, n2a, r2p,
                                       input logic [1:0] rd, dd);
      return {3'b011, op, t2n, t2r, n2a, r2p, rd, dd};
   endfunction

   function automatic logic [15:0] exp_alu(input logic [4:0] op, input logic [15:0] t, n,
                                           input int dp);
      logic [15:0] ad;
      case (op)
         0: return t;
         1: return n;
         2: return t + n;
         3: return t & n;
         4: return t | n;
         5: return t ^ n;
         6: return ~t;
         7: return (t == n) ? 16'hFFFF : 16'h0000;
         8: return ($signed(n) < $signed(t)) ? 16'hFFFF : 16'h0000;
         9: return n >> t[3:0];
         10: return t - 16'd1;
         12: begin
            ad = (t < 16'h4000) ? (t & 16'hFFFE) : t;
            return dmem[ad[7:0]];
         end
         13: return n << t[3:0];
         14: return 16'(dp);
         15: return (n < t) ? 16'hFFFF : 16'h0000;
         16: return n;
         17: return 16'h0000;
         18: return 16'h0000;
         19: return (t == 16'h0000) ? 16'hFFFF : 16'h0000;
         20: return TB_ID;
         default: return t;
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, exp);
      ntot++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = jmp(13'(i));
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 200000);
      nbad++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

   initial begin
      logic [15:0] a, b, e;
      logic [4:0]  op;
      logic        fa, fb;
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) dmem[i] = 16'hA000 ^ 16'(i * 7);

      // R12: state during and right after reset
      clear_prog();
      step(2);
      chk("R12 pc in reset", {3'b0, pc_out}, 16'h0000);
      chk("R12 T in reset", mem_wdata, 16'h0000);
      prog[0] = lit(15'd7);
      prog[1] = alu(5'd14, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[2] = alu(5'd18, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[3] = alu(5'd17, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[4] = alu(5'd20, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[5] = jmp(13'd5);
      restart();
      step(2);
      chk("R14 data depth after reset", mem_wdata, 16'd1);
      step(1);
      chk("R14 return depth after reset", mem_wdata, 16'd0);
      step(1);
      chk("R14 interrupt enable after reset", mem_wdata, 16'd0);
      step(1);
      chk("R4 cpu id", mem_wdata, TB_ID);
      chk("R12 pc ran from zero", {3'b0, pc_out}, 16'd5);

      // R4 R6 random ALU operations
      for (int k = 0; k < 60; k++) begin
         a  = 16'($urandom_range(0, 32767));
         b  = 16'($urandom_range(0, 32767));
         fa = 1'($urandom_range(0, 1));
         fb = 1'($urandom_range(0, 1));
         if (k % 5 == 0) b = a;
         if (k % 7 == 0) b = 16'($urandom_range(0, 20));
         op = 5'($urandom_range(0, 24));
         if (op == 5'd11) op = 5'd2;
         clear_prog();
         prog[0] = lit(a[14:0]);
         prog[1] = alu(fa ? 5'd6 : 5'd0, 0, 0, 0, 0, 2'b00, 2'b00);
         prog[2] = lit(b[14:0]);
         prog[3] = alu(fb ? 5'd6 : 5'd0, 0, 0, 0, 0, 2'b00, 2'b00);
         prog[4] = alu(op, 0, 0, 0, 0, 2'b00, 2'b11);
         prog[5] = jmp(13'd5);
         if (fa) a = ~a;
         if (fb) b = ~b;
         e = exp_alu(op, b, a, 2);
         restart();
         step(6);
         chk($sformatf("R4 R6 op %0d", op), mem_wdata, e);
      end

      // R6 directed signed vs unsigned compare: N=1, T=0xFFFF
      clear_prog();
      prog[0] = lit(15'd1);
      prog[1] = lit(15'd0);
      prog[2] = alu(5'd6, 0, 0, 0, 0, 2'b00, 2'b00);
      prog[3] = alu(5'd8, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[4] = alu(5'd1, 0, 0, 0, 0, 2'b00, 2'b11);
      prog[5] = alu(5'd15, 0, 0, 0, 0, 2'b00, 2'b11);
      prog[6] = jmp(13'd6);
      restart();
      step(4);
      chk("R6 signed 1 < -1 false", mem_wdata, 16'h0000);
      step(3);
      chk("R6 unsigned 1 < FFFF true", mem_wdata, 16'hFFFF);

      // R2 conditional branch, taken and not taken, with pop
      for (int v = 0; v < 2; v++) begin
         clear_prog();
         prog[0] = lit(15'h99);
         prog[1] = lit(15'(v));
         prog[2] = cjmp(13'd6);
         prog[3] = jmp(13'd3);
         prog[6] = jmp(13'd6);
         restart();
         step(4);
         chk("R2 cond branch pops", mem_wdata, 16'h0099);
         chk("R2 cond branch target", {3'b0, pc_out}, (v == 0) ? 16'd6 : 16'd3);
      end

      // R3 call and return, R5 return depth
      clear_prog();
      prog[0] = call(13'd4);
      prog[1] = alu(5'd18, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[2] = jmp(13'd2);
      prog[4] = alu(5'd11, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[5] = alu(5'd0, 0, 0, 0, 1, 2'b11, 2'b00);
      restart();
      step(2);
      chk("R3 return address on R", mem_wdata, 16'd1);
      step(1);
      chk("R3 return loads pc", {3'b0, pc_out}, 16'd1);
      step(1);
      chk("R5 return depth back to zero", mem_wdata, 16'd0);

      // R5 T to R and back
      clear_prog();
      prog[0] = lit(15'h11);
      prog[1] = lit(15'h55);
      prog[2] = alu(5'd1, 0, 1, 0, 0, 2'b01, 2'b11);
      prog[3] = alu(5'd11, 1, 0, 0, 0, 2'b11, 2'b01);
      prog[4] = jmp(13'd4);
      restart();
      step(3);
      chk("R5 T moved to R, N becomes T", mem_wdata, 16'h0011);
      step(1);
      chk("R5 R moved back to T", mem_wdata, 16'h0055);

      // R7 R8 R9 store with hold in the store cycle
      clear_prog();
      prog[0] = lit(15'h21);
      prog[1] = lit(15'h1234);
      prog[2] = alu(5'd1, 0, 0, 1, 0, 2'b00, 2'b11);
      prog[3] = lit(15'h4003);
      prog[4] = lit(15'h0BEE);
      prog[5] = alu(5'd0, 0, 0, 1, 0, 2'b00, 2'b00);
      prog[6] = lit(15'h31);
      prog[7] = alu(5'd12, 0, 0, 0, 0, 2'b00, 2'b00);
      prog[8] = jmp(13'd8);
      restart();
      step(2);
      hold = 1'b1;
      #1;
      chk("R9 no write during hold", {15'b0, mem_we}, 16'd1 ^ 16'd1);
      step(3);
      chk("R9 pc frozen", {3'b0, pc_out}, 16'd2);
      chk("R9 T frozen", mem_wdata, 16'h1234);
      hold = 1'b0;
      #1;
      chk("R7 write strobe", {15'b0, mem_we}, 16'd1);
      chk("R8 bit 0 cleared in RAM", mem_addr, 16'h0020);
      chk("R7 write data", mem_wdata, 16'h1234);
      step(1);
      chk("R7 stored word", dmem[8'h20], 16'h1234);
      chk("R8 odd cell untouched", dmem[8'h21], 16'hA000 ^ 16'(8'h21 * 7));
      step(2);
      chk("R8 IO address kept whole", mem_addr, 16'h4003);
      chk("R7 IO strobe", {15'b0, mem_we}, 16'd1);
      step(3);
      chk("R8 load from odd RAM address", mem_wdata, dmem[8'h30]);

      // R9 hold during a running loop
      clear_prog();
      prog[0] = lit(15'd5);
      prog[1] = alu(5'd10, 0, 0, 0, 0, 2'b00, 2'b00);
      prog[2] = jmp(13'd1);
      restart();
      step(3);
      hold = 1'b1;
      step(4);
      chk("R9 loop pc frozen", {3'b0, pc_out}, 16'd1);
      chk("R9 loop T frozen", mem_wdata, 16'd4);
      hold = 1'b0;
      step(1);
      chk("R9 resumes after hold", mem_wdata, 16'd3);

      // R13 65 values survive
      clear_prog();
      for (int j = 0; j < 65; j++) prog[j] = lit(15'(j + 1));
      for (int j = 65; j < 129; j++) prog[j] = alu(5'd1, 0, 0, 0, 0, 2'b00, 2'b11);
      prog[129] = jmp(13'd129);
      restart();
      step(65);
      chk("R13 last pushed on top", mem_wdata, 16'd65);
      step(64);
      chk("R13 first pushed value back after 64 pops", mem_wdata, 16'd1);

      // R10 R11 interrupts
      clear_prog();
      prog[0] = lit(15'd1);
      prog[1] = alu(5'd16, 0, 0, 0, 0, 2'b00, 2'b11);
      prog[2] = jmp(13'd2);
      prog[3] = lit(15'hABC);
      prog[4] = lit(15'd1);
      prog[5] = alu(5'd16, 0, 0, 0, 1, 2'b11, 2'b11);
      prog[7] = lit(15'h777);
      prog[8] = alu(5'd11, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[9] = alu(5'd17, 1, 0, 0, 0, 2'b00, 2'b01);
      prog[10] = jmp(13'd10);
      restart();
      irq_req = 1'b1;
      irq_num = 3'd7;
      step(1);
      irq_num = 3'd3;
      step(1);
      irq_req = 1'b0;
      chk("R11 no entry while disabled", {3'b0, pc_out}, 16'd2);
      step(2);
      chk("R11 lowest vector first", mem_wdata, 16'h0ABC);
      step(2);
      chk("R10 handler returns to interrupted pc", {3'b0, pc_out}, 16'd2);
      step(2);
      chk("R11 second vector served", mem_wdata, 16'h0777);
      step(1);
      chk("R10 interrupted address pushed", mem_wdata, 16'd2);
      step(1);
      chk("R10 enable cleared on entry", mem_wdata, 16'd0);

      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end
endmodule